// File: doc/BRIEF.md
# PHY Delay Register Bridge

This block gives a host indirect access to a small bank of PHY delay settings through a single 32-bit control word at a fixed byte offset. The host never addresses a delay entry directly. It loads a PHY address and a data nibble into the control word, then raises a write strobe bit or a read strobe bit. The bridge reacts once to each rising edge of a strobe. It writes the nibble into the addressed entry, or copies the addressed entry into a read-back field. It then raises a completion bit that the host polls.

The delay bank holds one entry per bus timing mode. It comes out of reset holding the start-up settings, so the PHY has sane delays before any software runs. The whole bank is also driven out in parallel on `dly_bank_o` to the delay lines it controls.

Top module: `phy_dly_bridge`

## Requirements
- R1: The control word answers only at byte offset 0x10. A read at any other offset returns zero, and a write at any other offset changes neither the control word nor the delay bank.
- R2: Control word layout: PHY address in bits [7:0], write nibble in bits [11:8], read-back nibble in bits [15:12], write strobe in bit 24, read strobe in bit 25, completion flag in bit 26. All other bits read as zero. Host writes to the read-back nibble and the completion flag have no effect on them.
- R3: After reset the control word reads zero. Delay entries 0 and 1 hold 4, entry 6 holds 9, entry 7 holds 2, entry 8 holds 3, and entries 2 to 5 hold 0.
- R4: A 0-to-1 change of the stored write strobe writes the write nibble into the entry selected by the PHY address exactly once. The write lands on the clock edge after the host write that set the strobe. Keeping the strobe high, or rewriting the word with the strobe still set, writes nothing more.
- R5: A write strobe edge with a PHY address above 8 leaves every entry of the bank unchanged.
- R6: A 0-to-1 change of the stored read strobe loads the addressed entry into the read-back nibble on the next clock edge. An address above 8 loads zero.
- R7: The completion flag is set on the clock edge after a strobe edge is accepted. It clears on the clock edge after both stored strobes are seen low.
- R8: The read-back nibble keeps its value until the next read strobe edge. Strobe clears and delay writes do not change it.
- R9: When both strobes rise in the same host write, the read-back nibble receives the entry's value from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write enable for one cycle |
| host_addr | input | HOST_ADDR_W (12) | Host byte offset for read and write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read of the word at host_addr |
| dly_bank_o | output | NUM_ENTRIES*DATA_W (36) | All delay entries, entry 0 in the low nibble |

## Verification
The bench targets three kinds of mistake. The first is a strobe held high or rewritten while set: a level-sensitive design would write again and overwrite the entry with newer data. The second is an address above 8: a design that truncates the index would alias it onto a real entry and corrupt that entry, or return that entry's data on a read. The third is a strobe pair raised in one write: a design that sequenced the read after the write would return the new nibble instead of the old one. The bench also checks that the read-back nibble survives later writes and strobe clears, and that the completion flag tracks the strobe levels with exactly one cycle of lag in each direction.

// File: rtl/phy_dly_pkg.sv
package phy_dly_pkg;

   // control word field positions
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned ADDR_LSB  = 0;
   localparam int unsigned WDATA_LSB = 8;
   localparam int unsigned RDATA_LSB = 12;
   localparam int unsigned WR_BIT    = 24;
   localparam int unsigned RD_BIT    = 25;
   localparam int unsigned ACK_BIT   = 26;
   localparam int unsigned NIBBLE_W  = 4;
   localparam int unsigned ADDR_FLD_W = 8;

   // start-up delay value of one bank entry
   function automatic logic [NIBBLE_W-1:0] boot_value(input int unsigned idx);
      logic [NIBBLE_W-1:0] v;
      case (idx)
         0, 1:    v = 4'd4;
         6:       v = 4'd9;
         7:       v = 4'd2;
         8:       v = 4'd3;
         default: v = 4'd0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/phy_dly_strobe_edge.sv
module phy_dly_strobe_edge #(
   parameter int unsigned NUM_STROBES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_STROBES-1:0] level_i,
   output logic [NUM_STROBES-1:0] rise_o
);

   generate
      if (NUM_STROBES < 1) begin : g_bad_cnt
         $error("NUM_STROBES must be at least 1");
      end
   endgenerate

   for (genvar g = 0; g < NUM_STROBES; g++) begin : g_edge
      logic prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= level_i[g];
      end

      assign rise_o[g] = level_i[g] & ~prev_q;

      // R4
      single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[g] |=> !rise_o[g]);
   end

endmodule

// File: rtl/phy_dly_regfile.sv
module phy_dly_regfile #(
   parameter int unsigned NUM_ENTRIES = 9,
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned IDX_W       = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  logic [IDX_W-1:0]              waddr_i,
   input  logic [DATA_W-1:0]             wdata_i,
   input  logic [IDX_W-1:0]              raddr_i,
   output logic [DATA_W-1:0]             rdata_o,
   output logic [NUM_ENTRIES*DATA_W-1:0] bank_o
);

   localparam int unsigned BANK_W = NUM_ENTRIES * DATA_W;

   generate
      if (NUM_ENTRIES < 1 || NUM_ENTRIES > (1 << IDX_W)) begin : g_bad_depth
         $error("NUM_ENTRIES does not fit the index width");
      end
      if (DATA_W < 1 || DATA_W > phy_dly_pkg::NIBBLE_W) begin : g_bad_width
         $error("DATA_W must be 1..4");
      end
   endgenerate

   logic [NUM_ENTRIES-1:0][DATA_W-1:0] ent_q;

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
      localparam logic [DATA_W-1:0] BOOT = DATA_W'(phy_dly_pkg::boot_value(g));
      logic hit;
      assign hit = we_i && (waddr_i == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   ent_q[g] <= BOOT;
         else if (hit) ent_q[g] <= wdata_i;
      end

      // R4
      entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(we_i && waddr_i == IDX_W'(g)) |=> $stable(bank_o[g*DATA_W +: DATA_W]));
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (raddr_i == IDX_W'(i)) rdata_o = ent_q[i];
      end
   end

   assign bank_o = BANK_W'(ent_q);

   // R5
   bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && int'(waddr_i) >= NUM_ENTRIES) |=> $stable(bank_o));

endmodule

// File: rtl/phy_dly_host_port.sv
module phy_dly_host_port #(
   parameter int unsigned         HOST_ADDR_W = 12,
   parameter logic [31:0]         PORT_OFFSET = 32'h10,
   parameter int unsigned         DATA_W      = 4,
   parameter int unsigned         PHY_ADDR_W  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic [HOST_ADDR_W-1:0] addr_i,
   input  logic [31:0]            wdata_i,
   output logic [31:0]            rdata_o,
   output logic [PHY_ADDR_W-1:0]  phy_addr_o,
   output logic [DATA_W-1:0]      phy_wdata_o,
   output logic                   wr_lvl_o,
   output logic                   rd_lvl_o,
   input  logic                   wr_rise_i,
   input  logic                   rd_rise_i,
   input  logic [DATA_W-1:0]      rd_value_i
);

   import phy_dly_pkg::*;

   generate
      if (PHY_ADDR_W < 1 || PHY_ADDR_W > ADDR_FLD_W) begin : g_bad_addr
         $error("PHY_ADDR_W must be 1..8");
      end
      if (HOST_ADDR_W < 5 || HOST_ADDR_W > 32) begin : g_bad_host
         $error("HOST_ADDR_W must be 5..32");
      end
   endgenerate

   logic                  sel;
   logic                  sel_wr;
   logic [PHY_ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0]     wdat_q;
   logic                  wr_q;
   logic                  rd_q;
   logic                  ack_q;
   logic [DATA_W-1:0]     rdat_q;
   logic [31:0]           word;

   assign sel    = (addr_i == HOST_ADDR_W'(PORT_OFFSET));
   assign sel_wr = wr_en_i && sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         wdat_q <= '0;
         wr_q   <= 1'b0;
         rd_q   <= 1'b0;
      end else if (sel_wr) begin
         addr_q <= wdata_i[ADDR_LSB +: PHY_ADDR_W];
         wdat_q <= wdata_i[WDATA_LSB +: DATA_W];
         wr_q   <= wdata_i[WR_BIT];
         rd_q   <= wdata_i[RD_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ack_q <= 1'b0;
      else if (wr_rise_i || rd_rise_i)  ack_q <= 1'b1;
      else if (!wr_q && !rd_q)          ack_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdat_q <= '0;
      else if (rd_rise_i) rdat_q <= rd_value_i;
   end

   always_comb begin
      word = '0;
      word[ADDR_LSB  +: PHY_ADDR_W] = addr_q;
      word[WDATA_LSB +: DATA_W]     = wdat_q;
      word[RDATA_LSB +: DATA_W]     = rdat_q;
      word[WR_BIT]                  = wr_q;
      word[RD_BIT]                  = rd_q;
      word[ACK_BIT]                 = ack_q;
   end

   assign rdata_o     = sel ? word : 32'h0;
   assign phy_addr_o  = addr_q;
   assign phy_wdata_o = wdat_q;
   assign wr_lvl_o    = wr_q;
   assign rd_lvl_o    = rd_q;

   // R7
   ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise_i || rd_rise_i) |=> ack_q);

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lvl_o && !rd_lvl_o) |=> !ack_q);

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_rise_i |=> $stable(rdat_q));

   // R1
   offset_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !sel) |=> $stable({addr_q, wdat_q, wr_q, rd_q}));

endmodule

// File: rtl/phy_dly_bridge.sv
module phy_dly_bridge #(
   parameter int unsigned HOST_ADDR_W = 12,
   parameter logic [31:0] PORT_OFFSET = 32'h10,
   parameter int unsigned NUM_ENTRIES = 9,
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned PHY_ADDR_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          host_wr_en,
   input  logic [HOST_ADDR_W-1:0]        host_addr,
   input  logic [31:0]                   host_wdata,
   output logic [31:0]                   host_rdata,
   output logic [NUM_ENTRIES*DATA_W-1:0] dly_bank_o
);

   localparam int unsigned STB_WR = 0;
   localparam int unsigned STB_RD = 1;
   localparam int unsigned NUM_STB = 2;

   logic [PHY_ADDR_W-1:0] phy_addr;
   logic [DATA_W-1:0]     phy_wdata;
   logic [DATA_W-1:0]     phy_rdata;
   logic [NUM_STB-1:0]    lvl;
   logic [NUM_STB-1:0]    rise;

   phy_dly_host_port #(
      .HOST_ADDR_W (HOST_ADDR_W),
      .PORT_OFFSET (PORT_OFFSET),
      .DATA_W      (DATA_W),
      .PHY_ADDR_W  (PHY_ADDR_W)
   ) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (host_wr_en),
      .addr_i      (host_addr),
      .wdata_i     (host_wdata),
      .rdata_o     (host_rdata),
      .phy_addr_o  (phy_addr),
      .phy_wdata_o (phy_wdata),
      .wr_lvl_o    (lvl[STB_WR]),
      .rd_lvl_o    (lvl[STB_RD]),
      .wr_rise_i   (rise[STB_WR]),
      .rd_rise_i   (rise[STB_RD]),
      .rd_value_i  (phy_rdata)
   );

   phy_dly_strobe_edge #(
      .NUM_STROBES (NUM_STB)
   ) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (lvl),
      .rise_o  (rise)
   );

   phy_dly_regfile #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .DATA_W      (DATA_W),
      .IDX_W       (PHY_ADDR_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (rise[STB_WR]),
      .waddr_i (phy_addr),
      .wdata_i (phy_wdata),
      .raddr_i (phy_addr),
      .rdata_o (phy_rdata),
      .bank_o  (dly_bank_o)
   );

endmodule

// File: tb/phy_dly_bridge_tb_top.sv
module phy_dly_bridge_tb_top;

   localparam int NENT = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [11:0] host_addr = 12'h010;
   logic [31:0] host_wdata = 32'h0;
   logic [31:0] host_rdata;
   logic [35:0] dly_bank;

   always #5 clk = ~clk;

   phy_dly_bridge dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr_en (host_wr_en),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .dly_bank_o (dly_bank)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [3:0] model [NENT];
   logic [7:0] cur_a;
   logic [3:0] cur_d;
   logic       cur_wr, cur_rd, exp_ack;
   logic [3:0] exp_rd;

   function automatic logic [3:0] boot(input int i);
      case (i)
         0, 1: return 4'd4;
         6:    return 4'd9;
         7:    return 4'd2;
         8:    return 4'd3;
         default: return 4'd0;
      endcase
   endfunction

   function automatic logic [31:0] pw(input logic [7:0] a, input logic [3:0] d,
                                      input logic wr, input logic rd);
      return {6'b0, rd, wr, 12'h0, d, a};
   endfunction

   function automatic logic [31:0] exp_word();
      return {5'b0, exp_ack, cur_rd, cur_wr, 8'h00, exp_rd, cur_d, cur_a};
   endfunction

   function automatic logic [35:0] exp_bank();
      logic [35:0] v;
      for (int i = 0; i < NENT; i++) v[i*4 +: 4] = model[i];
      return v;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [11:0] off, input logic [31:0] w);
      @(negedge clk);
      host_addr  = off;
      host_wdata = w;
      host_wr_en = 1'b1;
      @(negedge clk);
      host_wr_en = 1'b0;
      host_addr  = 12'h010;
      if (off == 12'h010) begin
         cur_a  = w[7:0];
         cur_d  = w[11:8];
         cur_wr = w[24];
         cur_rd = w[25];
      end
   endtask

   // full strobe sequence; wr/rd pick which strobes rise together
   task automatic access(input logic [7:0] a, input logic [3:0] d,
                         input logic wr, input logic rd, input string req);
      host_wr(12'h010, pw(a, d, 1'b0, 1'b0));
      chk({req, " R2 staged word"}, 64'(host_rdata), 64'(exp_word()));
      host_wr(12'h010, pw(a, d, wr, rd));
      @(negedge clk);
      exp_ack = 1'b1;
      if (rd) exp_rd = (a < NENT) ? model[a] : 4'd0;
      if (wr && a < NENT) model[a] = d;
      chk({req, " R7 ack set"}, 64'(host_rdata), 64'(exp_word()));
      chk({req, " R4 bank"}, 64'(dly_bank), 64'(exp_bank()));
      host_wr(12'h010, pw(a, d, 1'b0, 1'b0));
      chk({req, " R7 ack lag"}, 64'(host_rdata[26]), 64'(1'b1));
      @(negedge clk);
      exp_ack = 1'b0;
      chk({req, " R7 ack clear"}, 64'(host_rdata), 64'(exp_word()));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NENT; i++) model[i] = boot(i);
      cur_a = '0; cur_d = '0; cur_wr = 1'b0; cur_rd = 1'b0;
      exp_ack = 1'b0; exp_rd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 reset state
      chk("R3 word", 64'(host_rdata), 64'h0);
      chk("R3 bank", 64'(dly_bank), 64'(exp_bank()));

      // R1 other offset
      host_addr = 12'h014;
      #1;
      chk("R1 other offset reads zero", 64'(host_rdata), 64'h0);
      host_wr(12'h014, pw(8'h00, 4'hF, 1'b1, 1'b0));
      repeat (2) @(negedge clk);
      chk("R1 other offset word unchanged", 64'(host_rdata), 64'(exp_word()));
      chk("R1 other offset bank unchanged", 64'(dly_bank), 64'(exp_bank()));

      // R2 read-only fields ignore host writes
      host_wr(12'h010, 32'hFCFF_F003);
      cur_wr = 1'b0; cur_rd = 1'b0;
      host_wr(12'h010, pw(8'h03, 4'hF, 1'b0, 1'b0));
      chk("R2 read-only bits", 64'(host_rdata), 64'(exp_word()));

      // R6 read of start-up values
      access(8'h06, 4'h0, 1'b0, 1'b1, "R6 read entry6");
      access(8'h08, 4'h0, 1'b0, 1'b1, "R6 read entry8");
      // R4 plain write then read back
      access(8'h02, 4'hA, 1'b1, 1'b0, "R4 write entry2");
      access(8'h02, 4'h0, 1'b0, 1'b1, "R6 read entry2");
      chk("R6 read-back value", 64'(host_rdata[15:12]), 64'hA);

      // R8 read-back survives a later write
      access(8'h05, 4'h7, 1'b1, 1'b0, "R8 write after read");
      chk("R8 read-back held", 64'(host_rdata[15:12]), 64'hA);

      // R5 / R6 invalid addresses
      access(8'h09, 4'hC, 1'b1, 1'b0, "R5 write addr 9");
      access(8'hFF, 4'h5, 1'b1, 1'b0, "R5 write addr FF");
      access(8'h09, 4'h0, 1'b0, 1'b1, "R6 read addr 9");
      chk("R6 invalid read zero", 64'(host_rdata[15:12]), 64'h0);

      // R9 both strobes together
      access(8'h07, 4'hE, 1'b1, 1'b1, "R9 both strobes");
      chk("R9 old value returned", 64'(host_rdata[15:12]), 64'h2);

      // R4 rewrite with strobe still set: no second write
      host_wr(12'h010, pw(8'h01, 4'h6, 1'b0, 1'b0));
      host_wr(12'h010, pw(8'h01, 4'h6, 1'b1, 1'b0));
      @(negedge clk);
      model[1] = 4'h6;
      exp_ack = 1'b1;
      host_wr(12'h010, pw(8'h01, 4'hB, 1'b1, 1'b0));
      repeat (3) @(negedge clk);
      chk("R4 held strobe single write", 64'(dly_bank), 64'(exp_bank()));
      chk("R4 held strobe word", 64'(host_rdata), 64'(exp_word()));
      host_wr(12'h010, pw(8'h01, 4'hB, 1'b0, 1'b0));
      @(negedge clk);
      exp_ack = 1'b0;
      chk("R7 clear after held strobe", 64'(host_rdata), 64'(exp_word()));

      // random mix
      for (int k = 0; k < 80; k++) begin
         logic [7:0] a;
         logic [3:0] d;
         int op;
         a  = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 12);
         d  = 4'($urandom);
         op = $urandom % 3;
         case (op)
            0: access(a, d, 1'b1, 1'b0, "R4 random write");
            1: access(a, d, 1'b0, 1'b1, "R6 random read");
            default: access(a, d, 1'b1, 1'b1, "R9 random both");
         endcase
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule